// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block is a signed fixed-point accumulation datapath. It can accept one operand pair on each clock. In multiply mode it forms the full-precision product of the pair and adds that product into an accumulator register. In add mode it ignores the second operand and adds the first operand, sign-extended, directly.

No addition wraps. Each step whose true sum falls outside the accumulator's signed range is pinned to the nearest limit. Because the clamp is applied at every step and not only at the end, the result of a sequence depends on the order of its terms. A sticky flag records that at least one step clamped.

A clear strobe starts a new sum. When the strobe arrives together with a valid pair, that pair becomes the first term of the new sum, so no cycle is lost between sums. After n accepted pairs the accumulator holds the saturated sum of n terms.

Top module: `sat_mac`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator output is 0 and the saturation flag is 0.
- R2: With `add_mode_i`=0, each cycle with `vld_i`=1 adds the full-precision signed product `a_i*b_i` to the accumulator. One pair is taken per clock, and the new value appears on `acc_o` after that rising edge.
- R3: With `add_mode_i`=1, each valid cycle adds the sign-extended `a_i` to the accumulator, and `b_i` has no effect.
- R4: If a step's true sum exceeds 2^(ACC_W-1)-1, the accumulator takes that maximum. For ACC_W=8, 64 followed by 69 gives 127.
- R5: If a step's true sum is below -2^(ACC_W-1), the accumulator takes that minimum. For ACC_W=8, -127 followed by -5 gives -128.
- R6: Clamping happens at every step. For ACC_W=8 in add mode, the order 64, 70, -25 gives 102, and the order 70, -25, 64 gives 109.
- R7: `clr_i`=1 together with `vld_i`=1 discards the old sum, and the accumulator becomes that cycle's term alone, saturated.
- R8: `clr_i`=1 with `vld_i`=0 sets the accumulator to 0 and the saturation flag to 0.
- R9: `sat_o` rises after any step that clamps. It stays 1 until a clear strobe. After a clear that comes with a valid pair, it reflects only that pair's step.
- R10: With `vld_i`=0 and `clr_i`=0, both `acc_o` and `sat_o` keep their values, whatever `a_i`, `b_i` and `add_mode_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Start-of-sum strobe: discards the current sum and the saturation flag |
| vld_i | input | 1 | Operand pair valid; the pair is accumulated on this edge |
| add_mode_i | input | 1 | 0: accumulate a_i*b_i; 1: accumulate a_i |
| a_i | input | OP_W | Signed first operand or sample |
| b_i | input | OP_W | Signed second operand, unused in add mode |
| acc_o | output | ACC_W | Signed saturated accumulator value |
| sat_o | output | 1 | Sticky flag: some step of the current sum clamped |

## Verification
A corrupted accumulator shows on `acc_o` on the very next edge, because the output is the register itself. It then carries forward into every later sum until a clear. A missing per-step clamp, by contrast, can stay hidden until a term of the opposite sign arrives, which is why the order-dependent sequences matter. A flag that fails to set, or that drops without a clear, shows on `sat_o` one cycle after the offending step. The held-state cases catch a register that is enabled when it should not be: the output drifts in the cycle after the idle input.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  typedef enum logic {
    TERM_PRODUCT = 1'b0,
    TERM_SAMPLE  = 1'b1
  } term_sel_e;

  function automatic int unsigned wmax(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sat_mac_rst_sync.sv
module sat_mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mac_term.sv
module mac_term
  import sat_mac_pkg::*;
#(
  parameter int unsigned OP_W   = 8,
  parameter int unsigned TERM_W = 2 * OP_W
) (
  input  term_sel_e               sel,
  input  logic signed [OP_W-1:0]  a,
  input  logic signed [OP_W-1:0]  b,
  output logic signed [TERM_W-1:0] term
);

  logic signed [TERM_W-1:0] prod;
  logic signed [TERM_W-1:0] samp;

  always_comb begin
    prod = TERM_W'(a) * TERM_W'(b);
    samp = TERM_W'(a);
    term = (sel == TERM_SAMPLE) ? samp : prod;
  end

endmodule

// File: rtl/sat_add.sv
module sat_add
  import sat_mac_pkg::*;
#(
  parameter int unsigned ACC_W  = 8,
  parameter int unsigned TERM_W = 16
) (
  input  logic signed [ACC_W-1:0]  base,
  input  logic signed [TERM_W-1:0] term,
  output logic signed [ACC_W-1:0]  res,
  output logic                     ovf_hi,
  output logic                     ovf_lo
);

  localparam int unsigned SUM_W = wmax(ACC_W, TERM_W) + 1;
  localparam int unsigned TOP_N = SUM_W - ACC_W + 1;

  logic signed [SUM_W-1:0] base_x;
  logic signed [SUM_W-1:0] term_x;
  logic signed [SUM_W-1:0] sum;
  logic [TOP_N-1:0]        top_bits;
  logic                    fits;

  always_comb begin
    base_x   = SUM_W'(base);
    term_x   = SUM_W'(term);
    sum      = base_x + term_x;
    top_bits = sum[SUM_W-1:ACC_W-1];
    fits     = (top_bits == '0) || (top_bits == '1);
    ovf_hi   = !fits && !sum[SUM_W-1];
    ovf_lo   = !fits &&  sum[SUM_W-1];
    if (ovf_hi)      res = {1'b0, {(ACC_W-1){1'b1}}};
    else if (ovf_lo) res = {1'b1, {(ACC_W-1){1'b0}}};
    else             res = sum[ACC_W-1:0];
  end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic                    add_mode_i,
  input  logic signed [OP_W-1:0]  a_i,
  input  logic signed [OP_W-1:0]  b_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    sat_o
);

  localparam int unsigned TERM_W = 2 * OP_W;

  logic                     rst_s_n;
  term_sel_e                sel;
  logic signed [TERM_W-1:0] term;
  logic signed [ACC_W-1:0]  base;
  logic signed [ACC_W-1:0]  sum_sat;
  logic                     ovf_hi, ovf_lo;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     sat_q, sat_d;
  logic                     acc_en;

  sat_mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign sel = add_mode_i ? TERM_SAMPLE : TERM_PRODUCT;

  mac_term #(.OP_W(OP_W), .TERM_W(TERM_W)) u_term (
    .sel  (sel),
    .a    (a_i),
    .b    (b_i),
    .term (term)
  );

  sat_add #(.ACC_W(ACC_W), .TERM_W(TERM_W)) u_add (
    .base   (base),
    .term   (term),
    .res    (sum_sat),
    .ovf_hi (ovf_hi),
    .ovf_lo (ovf_lo)
  );

  // next-state: a clear zeroes the base the new term lands on
  always_comb begin
    base   = clr_i ? '0 : acc_q;
    acc_en = vld_i | clr_i;
    acc_d  = acc_q;
    sat_d  = sat_q;
    if (vld_i) begin
      acc_d = sum_sat;
      sat_d = (sat_q & ~clr_i) | ovf_hi | ovf_lo;
    end else if (clr_i) begin
      acc_d = '0;
      sat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      acc_q <= '0;
      sat_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      sat_q <= sat_d;
    end
  end

  assign acc_o = acc_q;
  assign sat_o = sat_q;

  // R10: idle cycles leave the state untouched
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!vld_i && !clr_i) |=> ($stable(acc_q) && $stable(sat_q)));

  // R8: a lone clear empties sum and flag
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clr_i && !vld_i) |=> (acc_q == '0 && !sat_q));

  // R9: flag is sticky until a clear
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sat_q && !clr_i) |=> sat_q);

  // R9: a clamping step raises the flag
  assert_clamp_flags_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vld_i && (ovf_hi || ovf_lo)) |=> sat_q);

  // R4: a non-negative term never lowers a running sum
  assert_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vld_i && !clr_i && !term[TERM_W-1]) |=> ($signed(acc_q) >= $signed($past(acc_q))));

  // R5: a negative term never raises a running sum
  assert_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vld_i && !clr_i && term[TERM_W-1]) |=> ($signed(acc_q) <= $signed($past(acc_q))));

endmodule

// File: tb/tb_sat_mac.sv
module tb_sat_mac;

  localparam int OP_W  = 8;
  localparam int ACC_W = 8;
  localparam int MAXV  = (1 << (ACC_W - 1)) - 1;
  localparam int MINV  = -(1 << (ACC_W - 1));

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    clr_i, vld_i, add_mode_i;
  logic signed [OP_W-1:0]  a_i, b_i;
  logic signed [ACC_W-1:0] acc_o;
  logic                    sat_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    int    acc;
    bit    sat;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   m_acc = 0;
  bit   m_sat = 1'b0;

  always #5 clk = ~clk;

  sat_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .vld_i      (vld_i),
    .add_mode_i (add_mode_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .acc_o      (acc_o),
    .sat_o      (sat_o)
  );

  task automatic compare(input int exp_acc, input bit exp_sat, input string tag);
    vectors++;
    if (int'(acc_o) != exp_acc || sat_o !== exp_sat) begin
      miscompares++;
      $display("FAIL %s: acc=%0d sat=%0b expected acc=%0d sat=%0b",
               tag, acc_o, sat_o, exp_acc, exp_sat);
    end
  endtask

  // driver: apply one cycle, then push the reference result
  task automatic step(input bit c, input bit v, input bit m,
                      input int a, input int b, input string tag);
    int  base, term, s;
    bit  f;
    exp_t e;
    @(negedge clk);
    clr_i = c; vld_i = v; add_mode_i = m;
    a_i = OP_W'(a); b_i = OP_W'(b);
    @(posedge clk);
    if (v) begin
      base = c ? 0 : m_acc;
      term = m ? a : a * b;
      s = base + term;
      f = 1'b0;
      if (s > MAXV) begin s = MAXV; f = 1'b1; end
      else if (s < MINV) begin s = MINV; f = 1'b1; end
      m_acc = s;
      m_sat = (c ? 1'b0 : m_sat) | f;
    end else if (c) begin
      m_acc = 0;
      m_sat = 1'b0;
    end
    e.acc = m_acc; e.sat = m_sat; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare one result per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      compare(e.acc, e.sat, e.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, queue=%0d expected 0", sb_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; vld_i = 1'b0; add_mode_i = 1'b0;
    a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    compare(0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(0, 1'b0, "R1 after reset");

    // R7 / R2: multiply mode, new sum starts with the first pair
    step(1, 1, 0,  3,  4, "R7 clear with first pair");
    step(0, 1, 0,  5, -2, "R2 signed product");
    step(0, 1, 0, -3, -3, "R2 negative times negative");
    // R3: add mode, b ignored
    step(1, 1, 1, 10, 99, "R3 sample with b ignored");
    step(0, 1, 1, -4, -77, "R3 negative sample");
    // R10: idle with noise on operands
    step(0, 0, 0, 120, 120, "R10 idle holds");
    step(0, 0, 1, -99, 5, "R10 idle holds again");
    // R4 / R9
    step(1, 1, 1, 64, 0, "R4 first term");
    step(0, 1, 1, 69, 0, "R4 positive clamp");
    step(0, 1, 1, -1, 0, "R9 flag sticky");
    step(0, 0, 0,  0, 0, "R9 flag held when idle");
    // R8
    step(1, 0, 0, 50, 50, "R8 lone clear");
    // R5
    step(1, 1, 1, -127, 0, "R5 first term");
    step(0, 1, 1,   -5, 0, "R5 negative clamp");
    // R6: order dependence
    step(1, 1, 1,  64, 0, "R6 order A term1");
    step(0, 1, 1,  70, 0, "R6 order A term2");
    step(0, 1, 1, -25, 0, "R6 order A gives 102");
    step(1, 1, 1,  70, 0, "R6 order B term1");
    step(0, 1, 1, -25, 0, "R6 order B term2");
    step(0, 1, 1,  64, 0, "R6 order B gives 109");
    // R9: clear with valid pair clears flag then reflects that step
    step(1, 1, 0, 2, 2, "R9 clear drops flag");
    // R4 / R5 with full-width products
    step(1, 1, 0,  127,  127, "R4 product clamp");
    step(0, 1, 0, -128,  127, "R5 product clamp");
    step(1, 1, 0, -128, -128, "R4 largest product");
    step(0, 1, 0,    1,    1, "R2 add after clamp");
    // R2 back-to-back mixed sequence
    step(1, 0, 0, 0, 0, "R8 clear before run");
    for (int i = 0; i < 40; i++) begin
      step(0, 1, i[0], (i * 7) % 23 - 11, (i * 5) % 13 - 6, "R2 streaming run");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule